// File: doc/BRIEF.md
# GPIO Expander Command-Pointer Register Bank

This block holds the register set of a 16-pin serial-bus I/O expander and sits behind a byte-level transaction layer. That layer reports three events. A strobe marks the start of a write transaction. A second strobe carries each written byte. A third strobe requests one read byte. The first byte written after a start is taken as an 8-bit command pointer. Any further bytes in the same transaction overwrite the register that the pointer selects. Every read returns the selected register, and the pointer keeps its value until a new command byte arrives.

The map has two sparse banks, chosen by pointer bit 6. The standard bank spans 0x00–0x07 and holds input, output, polarity and direction registers. The extended bank spans 0x40–0x4F and holds drive strength, input latch, pull enable, pull select, interrupt mask, interrupt status and an output-port mode byte. Each address has its own default value and access rule. The bank drives the per-pin output value, the output enable, and the pull enable and select lines straight from its registers.

A small state machine tracks the transaction. It has three states. ST_IDLE means no write transaction is open. ST_CMD means the next byte is the command. ST_DATA means the next bytes are register data. The transitions are:
- START: any state goes to ST_CMD on `txn_start`.
- LOAD: ST_CMD goes to ST_DATA when a byte is written.
- CLOSE: any state goes to ST_IDLE on `rd_stb`, because a read ends the write phase.
- HOLD: in all other cases the state stays as it is.
- SOFT: `soft_rst` forces ST_IDLE.

Top module: `gpx_regbank`

## Requirements
- R1: After `rst_n` is released, the bank is in its reset state. The pointer is 0x00 and `pin_out` is 0xFFFF. `pin_oe` is 0x0000, `pull_en` is 0x0000 and `pull_sel` is 0xFFFF. A read before any command returns input port 0.
- R2: After `txn_start`, the first `wr_stb` byte loads the command pointer and writes no register. Each later `wr_stb` byte writes the register the pointer selects.
- R3: `rd_stb` returns the selected register on `rd_data`, with `rd_vld` high in the next cycle. A read never changes the pointer, so repeated reads keep selecting the same register.
- R4: Standard addresses are 0x00/0x01 input, 0x02/0x03 output, 0x04/0x05 polarity and 0x06/0x07 direction. The even address serves pins 7..0 and the odd address serves pins 15..8, with bit i mapping to pin i of that byte.
- R5: Extended addresses have these defaults. 0x40–0x43 are 0xFF, 0x44/0x45 are 0x00, 0x46/0x47 are 0x00, 0x48/0x49 are 0xFF, 0x4A/0x4B are 0xFF, 0x4C/0x4D are 0x00 and 0x4F is 0x00. The writable ones read back what was written.
- R6: Writes to 0x00, 0x01, 0x4C and 0x4D are ignored and change no state.
- R7: Every address other than 0x00–0x07 and 0x40–0x4D, 0x4F is unmapped. A write to it changes nothing, and a read from it returns 0x00.
- R8: Reading 0x00 or 0x01 returns the pin levels, sampled at the `rd_stb` edge, XORed with the matching polarity register.
- R9: `pin_out` equals the output registers. `pin_oe` is the inverse of the direction registers, where a direction bit of 1 means input. `pull_en` and `pull_sel` equal the pull enable and pull select registers.
- R10: Several data bytes in one transaction all go to the same register, with no address increment, and the last byte wins.
- R11: `soft_rst` restores every register to its default and clears the pointer. It also returns the state machine to ST_IDLE, all on the same edge.
- R12: A `wr_stb` byte outside an open write transaction (ST_IDLE) is ignored. If `txn_start` and `wr_stb` occur in the same cycle, the start wins and that byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset |
| txn_start | input | 1 | Start of a write transaction |
| wr_stb | input | 1 | Written byte is valid |
| wr_data | input | 8 | Written byte |
| rd_stb | input | 1 | Request one read byte |
| rd_vld | output | 1 | Read byte valid, one cycle after `rd_stb` |
| rd_data | output | 8 | Read byte |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Output drive value per pin |
| pin_oe | output | 16 | Output enable per pin |
| pull_en | output | 16 | Pull resistor enable per pin |
| pull_sel | output | 16 | Pull direction per pin (1 = up) |

## Verification
A corrupted pointer is invisible until the next read, which is one cycle after `rd_stb`. At that point it returns a wrong register or 0x00 instead of stored data. A wrong state-machine state shows up on the very next written byte. Either a register write is lost, or the byte lands as a pointer and then redirects a later read. A bad write-enable decode shows on the pin outputs on the edge after the byte, or as a changed value on read-back. The bench therefore follows every write burst with read-backs and pin checks, so each fault is caught within a few cycles of its cause.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int BYTE_W   = 8;
    localparam int NPORTS   = 2;
    localparam int PIN_W    = BYTE_W * NPORTS;
    localparam int SLOTS    = 24;
    localparam int SLOT_W   = $clog2(SLOTS);

    // slot numbering: standard bank = low[2:0], extended bank = 8 + low[3:0]
    localparam int SLOT_IN0   = 0;
    localparam int SLOT_OUT0  = 2;
    localparam int SLOT_POL0  = 4;
    localparam int SLOT_DIR0  = 6;
    localparam int SLOT_DRV0  = 8;
    localparam int SLOT_LAT0  = 12;
    localparam int SLOT_PEN0  = 14;
    localparam int SLOT_PSEL0 = 16;
    localparam int SLOT_MSK0  = 18;
    localparam int SLOT_STS0  = 20;
    localparam int SLOT_HOLE  = 22;
    localparam int SLOT_OPC   = 23;

    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2
    } txn_state_e;

    function automatic byte_t slot_default(input int s);
        if ((s >= SLOT_OUT0 && s < SLOT_POL0) ||
            (s >= SLOT_DIR0 && s < SLOT_LAT0) ||
            (s >= SLOT_PSEL0 && s < SLOT_STS0))
            return '1;
        return '0;
    endfunction

    function automatic logic slot_is_writable(input int s);
        return !((s >= SLOT_IN0 && s < SLOT_IN0 + NPORTS) ||
                 (s >= SLOT_STS0 && s < SLOT_STS0 + NPORTS) ||
                 (s == SLOT_HOLE));
    endfunction

endpackage

// File: rtl/gpx_txn_fsm.sv
module gpx_txn_fsm
    import gpx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       txn_start,
    input  logic       wr_stb,
    input  logic       rd_stb,
    output logic       ptr_load,
    output logic       reg_wr,
    output txn_state_e state
);

    txn_state_e nxt_state;

    always_comb begin
        nxt_state = state;
        if (txn_start) begin
            nxt_state = ST_CMD;
        end else if (rd_stb) begin
            nxt_state = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: nxt_state = ST_IDLE;
                ST_CMD:  if (wr_stb) nxt_state = ST_DATA;
                ST_DATA: nxt_state = ST_DATA;
                default: nxt_state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state <= ST_IDLE;
        else if (soft_rst) state <= ST_IDLE;
        else               state <= nxt_state;
    end

    always_comb begin
        ptr_load = 1'b0;
        reg_wr   = 1'b0;
        if (!txn_start && !rd_stb && !soft_rst && wr_stb) begin
            unique case (state)
                ST_IDLE: ;
                ST_CMD:  ptr_load = 1'b1;
                ST_DATA: reg_wr   = 1'b1;
                default: ;
            endcase
        end
    end

    // R12
    idle_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !txn_start) |=> (state != ST_DATA));

    // R11
    soft_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (state == ST_IDLE));

endmodule

// File: rtl/gpx_addr_dec.sv
module gpx_addr_dec
    import gpx_pkg::*;
(
    input  byte_t ptr,
    output slot_t slot,
    output logic  mapped,
    output logic  writable
);

    logic ext_bank;
    logic upper_clear;

    assign ext_bank    = ptr[6];
    assign upper_clear = !ptr[7] && (ptr[5:4] == 2'b00);

    always_comb begin
        if (ext_bank) begin
            slot   = slot_t'(SLOT_DRV0) + slot_t'(ptr[3:0]);
            mapped = upper_clear && (slot_t'(ptr[3:0]) != slot_t'(SLOT_HOLE - SLOT_DRV0));
        end else begin
            slot   = slot_t'(ptr[2:0]);
            mapped = upper_clear && !ptr[3];
        end
        writable = mapped && slot_is_writable(int'(slot));
    end

endmodule

// File: rtl/gpx_reg_file.sv
module gpx_reg_file
    import gpx_pkg::*;
#(
    parameter int PORTS = NPORTS,
    localparam int PW   = PORTS * BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          wr_en,
    input  slot_t         slot,
    input  byte_t         wr_data,
    input  logic [PW-1:0] pin_in,
    output byte_t         rd_byte,
    output logic [PW-1:0] pin_out,
    output logic [PW-1:0] pin_oe,
    output logic [PW-1:0] pull_en,
    output logic [PW-1:0] pull_sel
);

    byte_t regs [SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) regs[i] <= slot_default(i);
        end else if (soft_rst) begin
            for (int i = 0; i < SLOTS; i++) regs[i] <= slot_default(i);
        end else if (wr_en) begin
            regs[slot] <= wr_data;
        end
    end

    always_comb begin
        rd_byte = regs[slot];
        for (int p = 0; p < PORTS; p++) begin
            if (slot == slot_t'(SLOT_IN0 + p))
                rd_byte = pin_in[p*BYTE_W +: BYTE_W] ^ regs[SLOT_POL0 + p];
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        assign pin_out [p*BYTE_W +: BYTE_W] = regs[SLOT_OUT0  + p];
        assign pin_oe  [p*BYTE_W +: BYTE_W] = ~regs[SLOT_DIR0 + p];
        assign pull_en [p*BYTE_W +: BYTE_W] = regs[SLOT_PEN0  + p];
        assign pull_sel[p*BYTE_W +: BYTE_W] = regs[SLOT_PSEL0 + p];
    end

    // R6
    status_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs[SLOT_STS0] == '0) && (regs[SLOT_STS0 + 1] == '0));

endmodule

// File: rtl/gpx_regbank.sv
module gpx_regbank
    import gpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             txn_start,
    input  logic             wr_stb,
    input  logic [7:0]       wr_data,
    input  logic             rd_stb,
    output logic             rd_vld,
    output logic [7:0]       rd_data,
    input  logic [PIN_W-1:0] pin_in,
    output logic [PIN_W-1:0] pin_out,
    output logic [PIN_W-1:0] pin_oe,
    output logic [PIN_W-1:0] pull_en,
    output logic [PIN_W-1:0] pull_sel
);

    byte_t      cmd_ptr;
    logic       ptr_load;
    logic       reg_wr;
    txn_state_e txn_state;
    slot_t      cur_slot;
    logic       ptr_mapped;
    logic       ptr_writable;
    byte_t      slot_byte;

    gpx_txn_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .txn_start (txn_start),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .ptr_load  (ptr_load),
        .reg_wr    (reg_wr),
        .state     (txn_state)
    );

    gpx_addr_dec u_dec (
        .ptr      (cmd_ptr),
        .slot     (cur_slot),
        .mapped   (ptr_mapped),
        .writable (ptr_writable)
    );

    gpx_reg_file #(.PORTS(NPORTS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_en    (reg_wr && ptr_writable),
        .slot     (cur_slot),
        .wr_data  (wr_data),
        .pin_in   (pin_in),
        .rd_byte  (slot_byte),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .pull_en  (pull_en),
        .pull_sel (pull_sel)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cmd_ptr <= '0;
        else if (soft_rst) cmd_ptr <= '0;
        else if (ptr_load) cmd_ptr <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_vld  <= 1'b0;
            rd_data <= '0;
        end else if (soft_rst) begin
            rd_vld  <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_vld <= rd_stb;
            if (rd_stb) rd_data <= ptr_mapped ? slot_byte : '0;
        end
    end

    // R3
    ptr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb && !soft_rst) |=> $stable(cmd_ptr));

    // R7
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !ptr_mapped && !soft_rst) |=> (rd_vld && rd_data == 8'h00));

    // R6
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !ptr_writable && !soft_rst) |=>
            ($stable(pin_out) && $stable(pin_oe) && $stable(pull_en) && $stable(pull_sel)));

    // R11
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cmd_ptr == 8'h00 && pin_oe == '0 && pin_out == '1 && pull_en == '0));

endmodule

// File: tb/gpx_regbank_tb.sv
module gpx_regbank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        txn_start = 1'b0;
    logic        wr_stb = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_stb = 1'b0;
    logic        rd_vld;
    logic [7:0]  rd_data;
    logic [15:0] pin_in = 16'hA53C;
    logic [15:0] pin_out, pin_oe, pull_en, pull_sel;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2 clk = ~clk;

    gpx_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .txn_start(txn_start),
        .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .rd_vld(rd_vld),
        .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pull_en(pull_en), .pull_sel(pull_sel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && rd_vld) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected read", 32'(rd_data), 32'hxx);
            end else begin
                check(tag_q.pop_front(), 32'(rd_data), 32'(exp_q.pop_front()));
            end
        end
    end

    task automatic start_txn();
        txn_start = 1'b1;
        @(negedge clk);
        txn_start = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        wr_stb = 1'b1; wr_data = b;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic get_byte(input logic [7:0] exp, input string req);
        exp_q.push_back(exp); tag_q.push_back(req);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic write_reg(input logic [7:0] cmd, input logic [7:0] val);
        start_txn(); put_byte(cmd); put_byte(val);
    endtask

    task automatic read_reg(input logic [7:0] cmd, input logic [7:0] exp, input string req);
        start_txn(); put_byte(cmd); get_byte(exp, req);
    endtask

    task automatic finish_run();
        @(negedge clk);
        check("R3 read queue drained", 32'(exp_q.size()), 32'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pin_out", 32'(pin_out), 32'hFFFF);
        check("R1 pin_oe", 32'(pin_oe), 32'h0000);
        check("R1 pull_en", 32'(pull_en), 32'h0000);
        check("R1 pull_sel", 32'(pull_sel), 32'hFFFF);
        get_byte(8'h3C, "R1 pointer 0 reads input 0");

        // R4 R2 output registers
        write_reg(8'h02, 8'h5A);
        write_reg(8'h03, 8'hC3);
        check("R4 pin_out bytes", 32'(pin_out), 32'hC35A);
        read_reg(8'h02, 8'h5A, "R2 output 0 readback");
        read_reg(8'h03, 8'hC3, "R4 output 1 readback");

        // R9 direction and pulls
        write_reg(8'h06, 8'h0F);
        write_reg(8'h07, 8'hF0);
        check("R9 pin_oe", 32'(pin_oe), 32'h0FF0);
        write_reg(8'h46, 8'h81);
        write_reg(8'h47, 8'h18);
        write_reg(8'h48, 8'h00);
        write_reg(8'h49, 8'h0F);
        check("R9 pull_en", 32'(pull_en), 32'h1881);
        check("R9 pull_sel", 32'(pull_sel), 32'h0F00);

        // R8 polarity
        write_reg(8'h04, 8'hFF);
        write_reg(8'h05, 8'h01);
        read_reg(8'h00, 8'hC3, "R8 input 0 inverted");
        read_reg(8'h01, 8'hA4, "R8 input 1 bit0 inverted");
        pin_in = 16'h1234;
        // R3 sticky pointer, repeated reads
        get_byte(8'h13, "R3 sticky read 1");
        get_byte(8'h13, "R3 sticky read 2");

        // R5 extended defaults and writes
        read_reg(8'h40, 8'hFF, "R5 drive 0 default");
        read_reg(8'h43, 8'hFF, "R5 drive 3 default");
        read_reg(8'h44, 8'h00, "R5 latch default");
        read_reg(8'h4A, 8'hFF, "R5 mask default");
        read_reg(8'h4D, 8'h00, "R5 status default");
        read_reg(8'h4F, 8'h00, "R5 port mode default");
        write_reg(8'h4F, 8'h03);
        read_reg(8'h4F, 8'h03, "R5 port mode readback");
        write_reg(8'h41, 8'h77);
        read_reg(8'h41, 8'h77, "R5 drive 1 readback");

        // R6 read-only targets
        write_reg(8'h4C, 8'h55);
        read_reg(8'h4C, 8'h00, "R6 status write ignored");
        write_reg(8'h00, 8'hFF);
        read_reg(8'h00, 8'hCB, "R6 input write ignored");
        read_reg(8'h04, 8'hFF, "R6 polarity untouched");

        // R7 unmapped
        write_reg(8'h08, 8'h99);
        read_reg(8'h08, 8'h00, "R7 0x08 reads zero");
        read_reg(8'h4E, 8'h00, "R7 0x4E reads zero");
        read_reg(8'h80, 8'h00, "R7 0x80 reads zero");
        write_reg(8'h82, 8'h00);
        write_reg(8'h42 | 8'h10, 8'h00);
        check("R7 alias writes ignored", 32'(pin_out), 32'hC35A);
        read_reg(8'h42, 8'hFF, "R7 drive 2 untouched");

        // R10 burst to one register
        start_txn(); put_byte(8'h02); put_byte(8'h11); put_byte(8'h22);
        check("R10 last byte wins", 32'(pin_out), 32'hC322);

        // R12 byte outside transaction
        read_reg(8'h02, 8'h22, "R12 setup read");
        put_byte(8'h66);
        check("R12 idle byte ignored", 32'(pin_out), 32'hC322);
        get_byte(8'h22, "R12 pointer kept");
        txn_start = 1'b1; wr_stb = 1'b1; wr_data = 8'h06;
        @(negedge clk);
        txn_start = 1'b0; wr_stb = 1'b0;
        put_byte(8'h03); put_byte(8'h44);
        check("R12 start wins over byte", 32'(pin_out), 32'h4422);
        check("R12 direction untouched", 32'(pin_oe), 32'h0FF0);

        // R11 software reset
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        check("R11 pin_out", 32'(pin_out), 32'hFFFF);
        check("R11 pin_oe", 32'(pin_oe), 32'h0000);
        check("R11 pull_en", 32'(pull_en), 32'h0000);
        check("R11 pull_sel", 32'(pull_sel), 32'hFFFF);
        get_byte(8'h34, "R11 pointer and polarity cleared");
        read_reg(8'h4F, 8'h00, "R11 port mode default");
        read_reg(8'h41, 8'hFF, "R11 drive default");

        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule